// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit sits beside a serial transmitter/receiver pair and deals only with its modem handshake lines. The host writes a control register over a small register port. That register drives four active-low outputs: data-terminal-ready, request-to-send and two auxiliary lines. The host reads a status register that reports two things. The first is the level of four active-low modem inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. The second is a set of sticky flags that record input activity since the last status read.

Each input pin passes through a two-flop synchronizer before any edge is detected. Three of the flags record any change of their line. The ring flag records only the end of a ring, which is the pin returning high. Reading the status register clears all four flags. A change that lands in the same cycle as the read is kept, so no change is lost. Whenever a flag becomes set, a single-cycle event pulse tells the host to come and read.

A diagnostic loopback mode feeds the control bits back as the line inputs, and holds the external output pins inactive while it is on.

Top module: `mdm_unit`

## Requirements
- R1: With loopback off, control bit 0 set drives `dtr_n` low and control bit 1 set drives `rts_n` low. Each pin follows the register in the cycle after the write, and is high when its bit is clear.
- R2: With loopback off, control bit 2 drives `out1_n` low and control bit 3 drives `out2_n` low. Writing 0x08 leaves `dtr_n` and `rts_n` high with `out2_n` low. Writing 0x09 also pulls `dtr_n` low. Writing 0x0A pulls `rts_n` low and leaves `dtr_n` high.
- R3: `reg_addr` 0 selects the control register and 1 selects the status register. A control read returns bits 4:0 as last written, with bits 7:5 as 0. A write to the status address leaves the control register unchanged.
- R4: Status bits 7, 6, 5 and 4 report carrier detect, ring, data-set-ready and clear-to-send, as 1 when the pin is low. A pin change becomes visible to a status read sampled at the third rising edge after it, and not to one sampled at the second.
- R5: Status bits 3 (carrier), 1 (data-set-ready) and 0 (clear-to-send) become set when their line changes, and stay set through any number of further changes until a status read.
- R6: Status bit 2 becomes set only when the ring line goes from asserted to deasserted (pin low to high). The ring line becoming asserted does not set it.
- R7: A status read returns the flags as they stood before the read and clears them. A change detected in the same cycle as the read leaves its flag set.
- R8: With control bit 4 set, request-to-send feeds clear-to-send, data-terminal-ready feeds data-set-ready, auxiliary 1 feeds ring and auxiliary 2 feeds carrier. The external input pins are ignored, and all four output pins are held high.
- R9: `evt` is high for one cycle, in the cycle in which a flag first shows set. It does not pulse again for a flag that is already set.
- R10: After reset the control register is 0, all output pins are high, `reg_rdata` is 0, `evt` is low and every flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, updated the cycle after a read strobe |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| evt | output | 1 | One-cycle pulse when a status flag becomes set |

## Verification
The assertions check these on every cycle: how a control write reaches the pins, with and without loopback; that reserved bits read as zero; that writes to the status address are ignored; that flags stay set between reads; that a read clears or re-sets the flags; and that `evt` never fires while no flag is held. Other behaviours only the bench's scenarios can show. These are the synchronizer latency, the trailing-edge-only ring flag, the loopback line mapping with its immunity to the external pins, and the absence of a second event for a flag that is already set. The bench covers them with its per-cycle reference model and with directed sequences whose read values are worked out by hand.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int NLINES = 4;
    // line vector index order, shared by level and flag vectors
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    typedef struct packed {
        logic loop;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int           W          = 4,
    parameter logic [W-1:0] TRAIL_ONLY = 4'b0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_lvl,
    input  logic         clr,
    output logic [W-1:0] flags,
    output logic [W-1:0] set_now,
    output logic         evt
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flags_q;
    logic         evt_q;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_det
            if (TRAIL_ONLY[i]) begin : g_trail
                assign set_now[i] = prev_q[i] & ~line_lvl[i];
            end else begin : g_any
                assign set_now[i] = prev_q[i] ^ line_lvl[i];
            end
        end
    endgenerate

    logic [W-1:0] kept;
    logic [W-1:0] fresh;
    always_comb begin
        kept  = clr ? '0 : flags_q;
        fresh = set_now & ~kept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            prev_q  <= line_lvl;
            flags_q <= kept | set_now;
            evt_q   <= |fresh;
        end
    end

    assign flags = flags_q;
    assign evt   = evt_q;
endmodule

// File: rtl/mdm_unit.sv
module mdm_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic          reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          dtr_n,
    output logic          rts_n,
    output logic          out1_n,
    output logic          out2_n,
    input  logic          cts_n,
    input  logic          dsr_n,
    input  logic          ri_n,
    input  logic          dcd_n,
    output logic          evt
);
    localparam int RSVD_W = RW - CTRL_W;

    ctrl_t              ctrl_q;
    logic [NLINES-1:0]  pin_lvl;
    logic [NLINES-1:0]  sync_lvl;
    logic [NLINES-1:0]  loop_lvl;
    logic [NLINES-1:0]  line_lvl;
    logic [NLINES-1:0]  delta_flags;
    logic [NLINES-1:0]  delta_set;
    logic               stat_rd;
    logic [RW-1:0]      rdata_q;

    // Asserted level is high on every internal line vector.
    always_comb begin
        pin_lvl         = '0;
        pin_lvl[LN_CTS] = ~cts_n;
        pin_lvl[LN_DSR] = ~dsr_n;
        pin_lvl[LN_RI]  = ~ri_n;
        pin_lvl[LN_DCD] = ~dcd_n;
    end

    mdm_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_lvl),
        .q_sync  (sync_lvl)
    );

    always_comb begin
        loop_lvl         = '0;
        loop_lvl[LN_CTS] = ctrl_q.rts;
        loop_lvl[LN_DSR] = ctrl_q.dtr;
        loop_lvl[LN_RI]  = ctrl_q.aux1;
        loop_lvl[LN_DCD] = ctrl_q.aux2;
        line_lvl         = ctrl_q.loop ? loop_lvl : sync_lvl;
    end

    assign stat_rd = reg_rd & reg_addr;

    mdm_delta #(.W(NLINES), .TRAIL_ONLY(4'b0100)) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_lvl (line_lvl),
        .clr      (stat_rd),
        .flags    (delta_flags),
        .set_now  (delta_set),
        .evt      (evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && !reg_addr) begin
            ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            if (reg_addr) begin
                rdata_q <= {line_lvl[LN_DCD], line_lvl[LN_RI],
                            line_lvl[LN_DSR], line_lvl[LN_CTS],
                            delta_flags[LN_DCD], delta_flags[LN_RI],
                            delta_flags[LN_DSR], delta_flags[LN_CTS]};
            end else begin
                rdata_q <= {{RSVD_W{1'b0}}, ctrl_q};
            end
        end
    end

    assign reg_rdata = rdata_q;
    assign dtr_n     = ~ctrl_q.dtr  | ctrl_q.loop;
    assign rts_n     = ~ctrl_q.rts  | ctrl_q.loop;
    assign out1_n    = ~ctrl_q.aux1 | ctrl_q.loop;
    assign out2_n    = ~ctrl_q.aux2 | ctrl_q.loop;
endmodule

// File: rtl/mdm_unit_chk.sv
module mdm_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n,
    input logic       evt,
    input logic [4:0] ctrl_q,
    input logic [3:0] delta_flags,
    input logic [3:0] delta_set
);
    // R1
    dtr_rts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !reg_wdata[4]) |=>
        (dtr_n == !$past(reg_wdata[0]) && rts_n == !$past(reg_wdata[1])));

    // R2
    aux_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !reg_wdata[4]) |=>
        (out1_n == !$past(reg_wdata[2]) && out2_n == !$past(reg_wdata[3])));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_addr) |=> (reg_rdata[7:5] == 3'b000));

    // R3
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> $stable(ctrl_q));

    // R8
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[4]) |=>
        (dtr_n && rts_n && out1_n && out2_n));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr) |=>
        ((delta_flags & $past(delta_flags)) == $past(delta_flags)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && delta_set == 4'b0) |=> (delta_flags == 4'b0));

    // R7
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && delta_set != 4'b0) |=>
        (delta_flags == $past(delta_set)));

    // R9
    evt_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (delta_flags != 4'b0));
endmodule

bind mdm_unit mdm_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .dtr_n       (dtr_n),
    .rts_n       (rts_n),
    .out1_n      (out1_n),
    .out2_n      (out2_n),
    .evt         (evt),
    .ctrl_q      (ctrl_q),
    .delta_flags (delta_flags),
    .delta_set   (delta_set)
);

// File: tb/mdm_unit_test.sv
module mdm_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dtr_n, rts_n, out1_n, out2_n, evt;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .evt(evt)
    );

    // ---------------- behavioural reference model ----------------
    // line index: 0 cts, 1 dsr, 2 ri, 3 dcd ; 1 = asserted
    int m_ctrl, m_rdata, m_evt;
    int m_s1[4], m_s2[4], m_prev[4], m_flag[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_rdata = 0; m_evt = 0;
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_flag[i] = 0;
            end
        end else begin
            int cur[4];
            int setb[4];
            int rd_stat;
            int pins[4];
            bit lp;
            lp = m_ctrl[4];
            cur[0] = lp ? m_ctrl[1] : m_s2[0];
            cur[1] = lp ? m_ctrl[0] : m_s2[1];
            cur[2] = lp ? m_ctrl[2] : m_s2[2];
            cur[3] = lp ? m_ctrl[3] : m_s2[3];
            for (int i = 0; i < 4; i++)
                setb[i] = (i == 2) ? (m_prev[i] == 1 && cur[i] == 0)
                                   : (m_prev[i] != cur[i]);
            rd_stat = (reg_rd && reg_addr) ? 1 : 0;
            if (reg_rd) begin
                if (reg_addr)
                    m_rdata = cur[3]*128 + cur[2]*64 + cur[1]*32 + cur[0]*16
                            + m_flag[3]*8 + m_flag[2]*4 + m_flag[1]*2 + m_flag[0];
                else
                    m_rdata = m_ctrl;
            end
            m_evt = 0;
            for (int i = 0; i < 4; i++) begin
                int held;
                held = rd_stat ? 0 : m_flag[i];
                if (setb[i] && !held) m_evt = 1;
                m_flag[i] = (held || setb[i]) ? 1 : 0;
                m_prev[i] = cur[i];
            end
            pins[0] = !cts_n; pins[1] = !dsr_n; pins[2] = !ri_n; pins[3] = !dcd_n;
            for (int i = 0; i < 4; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = pins[i];
            end
            if (reg_wr && !reg_addr) m_ctrl = reg_wdata & 8'h1F;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int lp;
            lp = m_ctrl[4];
            check("R1 dtr_n", dtr_n, lp ? 1 : !m_ctrl[0]);
            check("R1 rts_n", rts_n, lp ? 1 : !m_ctrl[1]);
            check("R2 out1_n", out1_n, lp ? 1 : !m_ctrl[2]);
            check("R2 out2_n", out2_n, lp ? 1 : !m_ctrl[3]);
            check("R4 rdata", reg_rdata, m_rdata);
            check("R9 evt", evt, m_evt);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(bit a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int evt_count;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 rdata", reg_rdata, 0);
        check("R10 pins", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
        check("R10 evt", evt, 0);
        rd(1'b1, v); check("R10 status", v, 8'h00);

        // R2 encodings
        wr(1'b0, 8'h08);
        check("R2 0x08", {dtr_n, rts_n, out1_n, out2_n}, 4'b1110);
        wr(1'b0, 8'h09);
        check("R2 0x09", {dtr_n, rts_n, out2_n}, 3'b010);
        wr(1'b0, 8'h0A);
        check("R2 0x0A", {dtr_n, rts_n, out2_n}, 3'b100);
        // R1 all asserted
        wr(1'b0, 8'hEF);
        check("R1 all low", {dtr_n, rts_n, out1_n, out2_n}, 4'h0);
        // R3 reserved bits and ignored status write
        rd(1'b0, v); check("R3 ctrl read", v, 8'h0F);
        wr(1'b1, 8'h10);
        rd(1'b0, v); check("R3 status write ignored", v, 8'h0F);
        check("R3 pins unchanged", {dtr_n, rts_n, out1_n, out2_n}, 4'h0);
        wr(1'b0, 8'h00);

        // R4 latency, R7 coincident read, R9 event
        cts_n = 1'b0;
        @(negedge clk);
        rd(1'b1, v); check("R4 not yet visible", v, 8'h00);
        rd(1'b1, v); check("R4 visible, R7 flag before read", v, 8'h10);
        check("R9 evt pulse", evt, 1);
        rd(1'b1, v); check("R7 flag survives coincident read", v, 8'h11);
        rd(1'b1, v); check("R7 cleared", v, 8'h10);

        // R5 multiple changes stay set
        dsr_n = 1'b0; idle(3); dsr_n = 1'b1; idle(6);
        rd(1'b1, v); check("R5 dsr delta", v, 8'h12);
        rd(1'b1, v); check("R5 cleared", v, 8'h10);

        // R6 trailing edge only
        ri_n = 1'b0; idle(6);
        rd(1'b1, v); check("R6 leading edge no flag", v, 8'h50);
        ri_n = 1'b1; idle(6);
        rd(1'b1, v); check("R6 trailing edge flag", v, 8'h14);
        rd(1'b1, v); check("R6 cleared", v, 8'h10);

        // R9 no second event while flag held
        evt_count = 0;
        cts_n = 1'b1;
        for (int k = 0; k < 6; k++) begin @(negedge clk); evt_count += evt; end
        cts_n = 1'b0;
        for (int k = 0; k < 6; k++) begin @(negedge clk); evt_count += evt; end
        check("R9 single event", evt_count, 1);
        rd(1'b1, v); check("R9 flag held", v, 8'h11);
        rd(1'b1, v); check("R9 cleared", v, 8'h10);

        // R8 loopback
        wr(1'b0, 8'h12);
        check("R8 pins idle", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
        idle(4);
        rd(1'b1, v); check("R8 rts feeds cts", v, 8'h10);
        wr(1'b0, 8'h1D);
        dsr_n = 1'b0; idle(4); dsr_n = 1'b1; idle(4);
        rd(1'b1, v); check("R8 mapping, pins ignored", v, 8'hEB);
        rd(1'b1, v); check("R8 cleared", v, 8'hE0);
        check("R8 pins idle 2", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
        wr(1'b0, 8'h10); idle(2);
        rd(1'b1, v); check("R8 R6 loop ring trailing", v, 8'h0E);
        wr(1'b0, 8'h00); idle(3);
        rd(1'b1, v); check("R8 back to pins", v, 8'h11);
        rd(1'b1, v); check("R8 cleared again", v, 8'h10);
        wr(1'b0, 8'h03);
        check("R1 after loopback", {dtr_n, rts_n}, 2'b00);
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule